// File: doc/BRIEF.md
# SPI Mode Fault Detector

This block watches the slave-select line of an SPI peripheral and raises a sticky mode-fault flag. When the peripheral is a master, another device pulling slave-select low means two masters are fighting over the bus. In that case the block sets the flag and, in the same cycle, sends single-cycle recovery pulses. These pulses disable the SPI, set the transmit-empty flag, clear the bit-state counter and release the shared port pins to their general-purpose direction logic.

When the peripheral is a slave, the fault is a slave-select release in the middle of a transfer. How a transfer is framed depends on the clock phase bit:
- With phase 0, a transfer opens when slave-select falls.
- With phase 1, it opens on the first serial-clock movement away from its idle level.
- In both phases, a transfer closes once the shift engine's active indication has been seen and dropped and the serial clock rests at idle.

Slave-select and serial clock cross into the block through a two-flop synchronizer. The flag drives a maskable interrupt request. Software clears the flag by reading status while the flag is set and then writing control.

Top module: `spi_fault_watch`

## Requirements
- R1: While reset is high and on the first cycle after it, fault_flag, fault_irq, spe_clr, txe_set, cnt_clr and pin_release are all 0.
- R2: With master_sel=1 and fault_en=1, a low level on ss_n_in sets fault_flag on the third rising clock edge after the input changes.
- R3: In master mode, spe_clr, txe_set, cnt_clr and pin_release pulse high together for exactly one cycle, the cycle fault_flag first sets. A slave fault produces no recovery pulse.
- R4: With fault_en=0, fault_flag is never set and no recovery pulse occurs, whatever slave-select does.
- R5: As a slave with cpha=0, a transfer opens when synchronized slave-select falls. A rise of slave-select before the transfer closes sets fault_flag three edges after the rise.
- R6: As a slave with cpha=1, a transfer opens only when the synchronized serial clock differs from cpol while slave-select is low. Slave-select toggling with no clock movement sets no fault. A rise after the clock has moved does set the fault.
- R7: A slave transfer closes once xfer_active has been seen high and is then low with the serial clock at its idle level (equal to cpol). A slave-select rise after that sets no fault.
- R8: fault_irq equals fault_flag AND err_ie, registered, so it follows a change of err_ie one cycle later.
- R9: fault_flag is cleared only by a stat_rd pulse taken while fault_flag is 1, followed by a ctrl_wr pulse. A ctrl_wr without that preceding read leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_sel | input | 1 | 1 = peripheral is master, 0 = slave |
| fault_en | input | 1 | Mode-fault detection enable |
| err_ie | input | 1 | Error interrupt enable |
| cpha | input | 1 | Clock phase select |
| cpol | input | 1 | Clock polarity (idle level of serial clock) |
| ss_n_in | input | 1 | Slave-select pin, active low, asynchronous |
| sck_in | input | 1 | Serial clock pin, asynchronous |
| xfer_active | input | 1 | Shift engine has bits in flight |
| stat_rd | input | 1 | Status register read strobe |
| ctrl_wr | input | 1 | Control register write strobe |
| fault_flag | output | 1 | Sticky mode-fault flag |
| fault_irq | output | 1 | Interrupt request |
| spe_clr | output | 1 | Pulse: clear SPI enable |
| txe_set | output | 1 | Pulse: set transmit-empty flag |
| cnt_clr | output | 1 | Pulse: clear bit-state counter |
| pin_release | output | 1 | Pulse: return port pins to direction logic |

## Verification
A change on a pin input passes two synchronizer flops and the flag register, so fault_flag and the recovery pulses are due on the third rising edge after the change. The pulses must be low again on the fourth edge. A strobe on stat_rd, ctrl_wr or err_ie passes one register and is due on the next edge. Each driver step queues its expected values tagged with the absolute cycle they are due. The monitor compares them on the falling edge of exactly that cycle, and any item left behind an elapsed cycle counts as a failure. Negative cases re-sample several cycles past the due point to show the flag stayed low.

// File: rtl/spi_fault_pkg.sv
package spi_fault_pkg;
  // Number of flops in the pin synchronizer
  parameter int SYNC_DEPTH = 2;
  // Recovery actions issued on a master fault
  parameter int NUM_REC = 4;
  localparam int REC_SPE = 0;
  localparam int REC_TXE = 1;
  localparam int REC_CNT = 2;
  localparam int REC_PIN = 3;

  typedef enum logic [0:0] {
    XF_IDLE = 1'b0,
    XF_RUN  = 1'b1
  } xfer_state_e;

  typedef struct packed {
    logic ss_n;
    logic sck;
  } pin_pair_t;
endpackage

// File: rtl/spi_sig_sync.sv
module spi_sig_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_xfer_track.sv
module spi_xfer_track
  import spi_fault_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic slave_mode,
  input  logic cpha,
  input  logic cpol,
  input  logic ss_s,
  input  logic ss_fall,
  input  logic ss_rise,
  input  logic sck_s,
  input  logic xfer_active,
  output logic in_prog
);
  xfer_state_e state;
  logic        seen_act;
  logic        start;
  logic        sck_idle;

  assign sck_idle = (sck_s == cpol);
  // Phase 1 opens on clock leaving idle, phase 0 on select falling
  assign start = cpha ? (!ss_s && !sck_idle) : ss_fall;

  always_ff @(posedge clk) begin
    if (rst || !slave_mode) begin
      state    <= XF_IDLE;
      seen_act <= 1'b0;
    end else begin
      case (state)
        XF_IDLE: begin
          if (start) begin
            state    <= XF_RUN;
            seen_act <= xfer_active;
          end
        end
        XF_RUN: begin
          if (ss_rise) begin
            state    <= XF_IDLE;
            seen_act <= 1'b0;
          end else if (seen_act && !xfer_active && sck_idle) begin
            state    <= XF_IDLE;
            seen_act <= 1'b0;
          end else begin
            seen_act <= seen_act | xfer_active;
          end
        end
        default: state <= XF_IDLE;
      endcase
    end
  end

  assign in_prog = (state == XF_RUN);
endmodule

// File: rtl/spi_fault_core.sv
module spi_fault_core
  import spi_fault_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               master_sel,
  input  logic               fault_en,
  input  logic               err_ie,
  input  logic               ss_s,
  input  logic               ss_rise,
  input  logic               in_prog,
  input  logic               stat_rd,
  input  logic               ctrl_wr,
  output logic               flag,
  output logic               irq,
  output logic [NUM_REC-1:0] rec
);
  logic master_hit, slave_hit, set_c, clr_c, flag_d, armed;

  assign master_hit = master_sel && fault_en && !ss_s;
  assign slave_hit  = !master_sel && fault_en && ss_rise && in_prog;
  assign set_c      = master_hit || slave_hit;
  assign clr_c      = ctrl_wr && armed;

  always_comb begin
    flag_d = flag;
    if (clr_c) flag_d = 1'b0;
    if (set_c) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
      irq   <= 1'b0;
    end else begin
      flag <= flag_d;
      irq  <= flag_d && err_ie;
      if (stat_rd && flag) armed <= 1'b1;
      else if (ctrl_wr)    armed <= 1'b0;
    end
  end

  genvar k;
  generate
    for (k = 0; k < NUM_REC; k++) begin : g_rec
      always_ff @(posedge clk) begin
        if (rst) rec[k] <= 1'b0;
        else     rec[k] <= master_hit && !flag;
      end
    end
  endgenerate
endmodule

// File: rtl/spi_fault_watch.sv
module spi_fault_watch
  import spi_fault_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic master_sel,
  input  logic fault_en,
  input  logic err_ie,
  input  logic cpha,
  input  logic cpol,
  input  logic ss_n_in,
  input  logic sck_in,
  input  logic xfer_active,
  input  logic stat_rd,
  input  logic ctrl_wr,
  output logic fault_flag,
  output logic fault_irq,
  output logic spe_clr,
  output logic txe_set,
  output logic cnt_clr,
  output logic pin_release
);
  localparam int PW = $bits(pin_pair_t);

  pin_pair_t          raw, synced;
  logic               ss_q, ss_fall, ss_rise, in_prog;
  logic [NUM_REC-1:0] rec;

  assign raw.ss_n = ss_n_in;
  assign raw.sck  = sck_in;

  spi_sig_sync #(
    .W(PW), .STAGES(SYNC_DEPTH), .RST_VAL(PW'(2'b10))
  ) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  always_ff @(posedge clk) begin
    if (rst) ss_q <= 1'b1;
    else     ss_q <= synced.ss_n;
  end

  assign ss_fall = ss_q && !synced.ss_n;
  assign ss_rise = !ss_q && synced.ss_n;

  spi_xfer_track u_track (
    .clk(clk), .rst(rst), .slave_mode(!master_sel), .cpha(cpha),
    .cpol(cpol), .ss_s(synced.ss_n), .ss_fall(ss_fall),
    .ss_rise(ss_rise), .sck_s(synced.sck), .xfer_active(xfer_active),
    .in_prog(in_prog)
  );

  spi_fault_core u_core (
    .clk(clk), .rst(rst), .master_sel(master_sel), .fault_en(fault_en),
    .err_ie(err_ie), .ss_s(synced.ss_n), .ss_rise(ss_rise),
    .in_prog(in_prog), .stat_rd(stat_rd), .ctrl_wr(ctrl_wr),
    .flag(fault_flag), .irq(fault_irq), .rec(rec)
  );

  assign spe_clr     = rec[REC_SPE];
  assign txe_set     = rec[REC_TXE];
  assign cnt_clr     = rec[REC_CNT];
  assign pin_release = rec[REC_PIN];
endmodule

// File: rtl/spi_fault_watch_chk.sv
module spi_fault_watch_chk (
  input logic clk,
  input logic rst,
  input logic master_sel,
  input logic fault_en,
  input logic ctrl_wr,
  input logic fault_flag,
  input logic fault_irq,
  input logic spe_clr,
  input logic txe_set,
  input logic cnt_clr,
  input logic pin_release
);
  // R3
  rec_single_chk: assert property (@(posedge clk) disable iff (rst)
    spe_clr |=> !spe_clr);
  // R3
  rec_master_chk: assert property (@(posedge clk) disable iff (rst)
    spe_clr |-> (fault_flag && $past(master_sel)));
  // R3
  rec_group_chk: assert property (@(posedge clk) disable iff (rst)
    spe_clr |-> (txe_set && cnt_clr && pin_release));
  // R4
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_flag) |-> $past(fault_en));
  // R8
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    fault_irq |-> fault_flag);
  // R9
  clr_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_flag) |-> $past(ctrl_wr));
endmodule

bind spi_fault_watch spi_fault_watch_chk u_chk (
  .clk(clk), .rst(rst), .master_sel(master_sel), .fault_en(fault_en),
  .ctrl_wr(ctrl_wr), .fault_flag(fault_flag), .fault_irq(fault_irq),
  .spe_clr(spe_clr), .txe_set(txe_set), .cnt_clr(cnt_clr),
  .pin_release(pin_release)
);

// File: tb/spi_fault_watch_tb.sv
`timescale 1ns/100ps
module spi_fault_watch_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_sel = 1'b0, fault_en = 1'b0, err_ie = 1'b0;
  logic cpha = 1'b0, cpol = 1'b0, ss_n_in = 1'b1, sck_in = 1'b0;
  logic xfer_active = 1'b0, stat_rd = 1'b0, ctrl_wr = 1'b0;
  logic fault_flag, fault_irq, spe_clr, txe_set, cnt_clr, pin_release;

  always #2.5 clk = ~clk;

  spi_fault_watch u_dut (
    .clk(clk), .rst(rst), .master_sel(master_sel), .fault_en(fault_en),
    .err_ie(err_ie), .cpha(cpha), .cpol(cpol), .ss_n_in(ss_n_in),
    .sck_in(sck_in), .xfer_active(xfer_active), .stat_rd(stat_rd),
    .ctrl_wr(ctrl_wr), .fault_flag(fault_flag), .fault_irq(fault_irq),
    .spe_clr(spe_clr), .txe_set(txe_set), .cnt_clr(cnt_clr),
    .pin_release(pin_release)
  );

  typedef enum int {K_FLAG, K_IRQ, K_SPE, K_TXE, K_CNT, K_PIN} kind_e;
  typedef struct {
    int    due;
    kind_e kind;
    logic  val;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic pick(kind_e k);
    case (k)
      K_FLAG:  return fault_flag;
      K_IRQ:   return fault_irq;
      K_SPE:   return spe_clr;
      K_TXE:   return txe_set;
      K_CNT:   return cnt_clr;
      default: return pin_release;
    endcase
  endfunction

  // driver side: queue a value due dly edges from now
  task automatic expect_at(int dly, kind_e k, logic v, string r);
    exp_t e;
    e.due = cyc + dly; e.kind = k; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic expect_rec(int dly, logic v, string r);
    expect_at(dly, K_SPE, v, r);
    expect_at(dly, K_TXE, v, r);
    expect_at(dly, K_CNT, v, r);
    expect_at(dly, K_PIN, v, r);
  endtask

  // monitor: compare at falling edge of due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      logic a;
      e = q.pop_front();
      n_run++;
      a = pick(e.kind);
      if (e.due < cyc) begin
        n_fail++;
        $display("FAIL %s item %s missed its cycle %0d", e.req, e.kind.name(), e.due);
      end else if (a !== e.val) begin
        n_fail++;
        $display("FAIL %s %s actual=%b expected=%b cycle=%0d",
                 e.req, e.kind.name(), a, e.val, cyc);
      end
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_seq(string r);
    expect_at(2, K_FLAG, 1'b0, r);
    stat_rd = 1'b1; wait_n(1); stat_rd = 1'b0;
    ctrl_wr = 1'b1; wait_n(1); ctrl_wr = 1'b0;
    wait_n(2);
  endtask

  initial begin
    wait_n(1);
    // R1 reset state
    expect_at(1, K_FLAG, 1'b0, "R1");
    expect_at(1, K_IRQ, 1'b0, "R1");
    expect_rec(1, 1'b0, "R1");
    wait_n(3);
    rst = 1'b0;
    expect_at(1, K_FLAG, 1'b0, "R1");
    expect_rec(1, 1'b0, "R1");
    wait_n(2);

    // R2/R3 master fault
    master_sel = 1'b1; fault_en = 1'b1;
    ss_n_in = 1'b0;
    expect_at(2, K_FLAG, 1'b0, "R2");
    expect_at(3, K_FLAG, 1'b1, "R2");
    expect_rec(3, 1'b1, "R3");
    expect_at(3, K_IRQ, 1'b0, "R8");
    expect_rec(4, 1'b0, "R3");
    expect_at(4, K_FLAG, 1'b1, "R2");
    wait_n(6);
    // R8 interrupt enable
    err_ie = 1'b1;
    expect_at(1, K_IRQ, 1'b1, "R8");
    wait_n(2);
    ss_n_in = 1'b1;
    wait_n(4);
    // R9 write alone does not clear
    expect_at(2, K_FLAG, 1'b1, "R9");
    ctrl_wr = 1'b1; wait_n(1); ctrl_wr = 1'b0;
    wait_n(2);
    expect_at(2, K_IRQ, 1'b0, "R8");
    clear_seq("R9");
    err_ie = 1'b0;

    // R4 enable low
    fault_en = 1'b0;
    ss_n_in = 1'b0;
    expect_at(3, K_FLAG, 1'b0, "R4");
    expect_rec(3, 1'b0, "R4");
    expect_at(6, K_FLAG, 1'b0, "R4");
    wait_n(7);
    ss_n_in = 1'b1;
    wait_n(4);

    // R5 slave phase 0, select released mid transfer
    master_sel = 1'b0; fault_en = 1'b1; cpha = 1'b0; cpol = 1'b0; sck_in = 1'b0;
    wait_n(2);
    ss_n_in = 1'b0;
    wait_n(5);
    ss_n_in = 1'b1;
    expect_at(2, K_FLAG, 1'b0, "R5");
    expect_at(3, K_FLAG, 1'b1, "R5");
    expect_rec(3, 1'b0, "R3");
    wait_n(5);
    clear_seq("R9");

    // R7 completed transfer then release
    ss_n_in = 1'b0;
    wait_n(4);
    xfer_active = 1'b1;
    wait_n(4);
    xfer_active = 1'b0;
    wait_n(4);
    ss_n_in = 1'b1;
    expect_at(3, K_FLAG, 1'b0, "R7");
    expect_at(6, K_FLAG, 1'b0, "R7");
    wait_n(7);

    // R6 phase 1, no clock movement
    cpha = 1'b1; cpol = 1'b1; sck_in = 1'b1;
    wait_n(3);
    ss_n_in = 1'b0;
    wait_n(5);
    ss_n_in = 1'b1;
    expect_at(3, K_FLAG, 1'b0, "R6");
    expect_at(6, K_FLAG, 1'b0, "R6");
    wait_n(7);

    // R6 phase 1 with clock movement
    ss_n_in = 1'b0;
    wait_n(4);
    sck_in = 1'b0;
    wait_n(2);
    sck_in = 1'b1;
    wait_n(4);
    ss_n_in = 1'b1;
    expect_at(3, K_FLAG, 1'b1, "R6");
    expect_rec(3, 1'b0, "R3");
    wait_n(5);
    clear_seq("R9");

    wait_n(2);
    done = 1;
  end

  initial begin
    int t;
    t = 0;
    while (!done && t < 5000) begin
      @(posedge clk);
      t++;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
    end
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule